// File: doc/BRIEF.md
# Return-to-Zero Clock and Data Recovery

This block recovers a bit clock and two rail data bits from a return-to-zero pulse stream. The stream is observed with a reference clock that runs at thirteen times the nominal bit rate. The positive-rail and negative-rail pulse strobes arrive already synchronised to the reference clock, and each strobe lasts one reference tick. The block keeps a phase counter that nominally spans 13 ticks per recovered bit period. The ideal pulse position is phase 6, the middle tick.

The first pulse seen in a period places a mark in that period. It also re-centres the counter, so that the next expected pulse lies exactly 13 ticks after it. As a result, a single recovered period can shrink to 7 ticks or stretch to 19 ticks. Periods without a pulse carry a zero and run at the nominal 13 ticks. While the loss-of-signal input is high, realignment stops and the clock runs at the reference rate divided by 13. Pulses are still collected as data during that time.

Top module: `cdr_rz_recover`

## Requirements
- R1: While rst_ni is low, both data outputs are 0 and rclk_o is high, because the counter sits at period start.
- R2: A recovered period with no strobe on either rail is output as 0 on both rx_pos_o and rx_neg_o.
- R3: Without pulses and without loss of signal, every recovered period lasts 13 reference ticks, with rclk_o high for the first 6 of them.
- R4: When the first strobe of a period lands on phase k (0 to 12, with phase 0 the tick on which rclk_o goes high), that period lasts k+7 ticks. This gives 7 ticks for the earliest pulse and 19 ticks for the latest.
- R5: A strobe on pos_mark_i sets the positive bit of its period. A strobe on neg_mark_i sets the negative bit. Strobes on both rails in the same tick set both bits.
- R6: The period after a realigned one lasts 13 ticks. A pulse landing on phase 6 of that period is centred and leaves its length at 13.
- R7: While los_i is high, every period lasts 13 ticks and rclk_o stays high for 6 ticks, wherever the pulses fall.
- R8: While los_i is high, pulses are still delivered on the data outputs.
- R9: rclk_o is high for the first min(6, floor(L/2)) ticks of a period of length L, and low for the rest of that period.
- R10: The data outputs change only on the reference tick after an rclk_o falling edge. The bits of period n appear after the fall in period n+1 and hold until the fall in period n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, 13x bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_mark_i | input | 1 | Positive-rail pulse strobe, one tick wide |
| neg_mark_i | input | 1 | Negative-rail pulse strobe, one tick wide |
| los_i | input | 1 | Loss of signal; freezes the period at 13 ticks |
| rclk_o | output | 1 | Recovered bit clock |
| rx_pos_o | output | 1 | Recovered positive-rail bit |
| rx_neg_o | output | 1 | Recovered negative-rail bit |

## Verification
The main sweep places a single pulse on every phase 0 to 12 of a period, on the positive rail, the negative rail and both rails. It measures the period length and the rclk_o high time, which separates early realignment from late realignment and shows where the duty cap applies. Each hit is followed by a centred pulse with the rails swapped, then by empty periods. This checks the re-centring, the one-period output delay and the return to zero. A second sweep repeats the phase placement with loss of signal held high. There the length must stay at 13 ticks while the data still passes through.

// File: rtl/cdr_rz_pkg.sv
package cdr_rz_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;
endpackage

// File: rtl/cdr_phase_track.sv
module cdr_phase_track #(
  parameter int TICKS = 13,
  parameter int PW    = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  input  logic los_i,
  output logic rclk_o,
  output logic wrap_o
);
  localparam int CTR  = TICKS / 2;
  localparam int STEP = TICKS - CTR;
  localparam int HIGH = TICKS / 2;
  localparam int LMIN = STEP;
  localparam int LMAX = TICKS - 1 + STEP;

  logic [PW-1:0] phase_q, len_q, len_w, half_w, hi_lim;
  logic          locked_q, lock_w;

  // first mark of a period re-centres unless signal is lost
  assign lock_w = mark_i & ~locked_q & ~los_i;
  assign len_w  = lock_w ? phase_q + PW'(STEP) : len_q;
  assign wrap_o = (phase_q == len_w - PW'(1));

  assign half_w = len_q >> 1;
  assign hi_lim = (half_w < PW'(HIGH)) ? half_w : PW'(HIGH);
  assign rclk_o = (phase_q < hi_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= '0;
      len_q    <= PW'(TICKS);
      locked_q <= 1'b0;
    end else if (wrap_o) begin
      phase_q  <= '0;
      len_q    <= PW'(TICKS);
      locked_q <= 1'b0;
    end else begin
      phase_q <= phase_q + PW'(1);
      if (lock_w) begin
        len_q    <= len_w;
        locked_q <= 1'b1;
      end
    end
  end

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q >= PW'(LMIN)) && (len_q <= PW'(LMAX))); // R4
  AST_FREE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_q |-> len_q == PW'(TICKS)); // R3
  AST_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && !locked_q && !los_i) |=> len_q == $past(phase_q) + PW'(STEP)); // R4
  AST_LOS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_i && !locked_q && !wrap_o) |=> $stable(len_q)); // R7
  AST_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> rclk_o); // R9
endmodule

// File: rtl/cdr_bit_slot.sv
module cdr_bit_slot
  import cdr_rz_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rail_t mark_i,
  input  logic  wrap_i,
  input  logic  rclk_i,
  output rail_t data_o
);
  rail_t acc_q, pend_q, out_q;
  logic  rclk_q, fall_w;

  assign fall_w = rclk_q & ~rclk_i;
  assign data_o = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      pend_q <= '0;
      out_q  <= '0;
      rclk_q <= 1'b1;
    end else begin
      rclk_q <= rclk_i;
      if (wrap_i) begin
        pend_q <= acc_q | mark_i;
        acc_q  <= '0;
      end else begin
        acc_q <= acc_q | mark_i;
      end
      if (fall_w) out_q <= pend_q;
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_w |=> $stable(data_o)); // R10
endmodule

// File: rtl/cdr_rz_recover.sv
module cdr_rz_recover
  import cdr_rz_pkg::*;
#(
  parameter int TICKS = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_mark_i,
  input  logic neg_mark_i,
  input  logic los_i,
  output logic rclk_o,
  output logic rx_pos_o,
  output logic rx_neg_o
);
  localparam int LMAX = TICKS - 1 + (TICKS - TICKS / 2);
  localparam int PW   = $clog2(LMAX + 1);

  rail_t mark_w, data_w;
  logic  wrap_w;

  assign mark_w.pos = pos_mark_i;
  assign mark_w.neg = neg_mark_i;

  cdr_phase_track #(.TICKS(TICKS), .PW(PW)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mark_i (pos_mark_i | neg_mark_i),
    .los_i  (los_i),
    .rclk_o (rclk_o),
    .wrap_o (wrap_w)
  );

  cdr_bit_slot u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mark_i (mark_w),
    .wrap_i (wrap_w),
    .rclk_i (rclk_o),
    .data_o (data_w)
  );

  assign rx_pos_o = data_w.pos;
  assign rx_neg_o = data_w.neg;
endmodule

// File: tb/cdr_rz_recover_bench.sv
module cdr_rz_recover_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pos_i = 1'b0, neg_i = 1'b0, los_i = 1'b0;
  logic rclk_o, rx_pos_o, rx_neg_o;
  int   n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cdr_rz_recover u_cdr_rz_recover (
    .clk_i(clk), .rst_ni(rst_ni), .pos_mark_i(pos_i), .neg_mark_i(neg_i),
    .los_i(los_i), .rclk_o(rclk_o), .rx_pos_o(rx_pos_o), .rx_neg_o(rx_neg_o)
  );

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // starts at a negedge on phase 0; pulse on phase k (k<0: none); ends at next phase 0
  task automatic run_period(input int k, input logic p, input logic n,
                            output int len, output int hi);
    bit seen_low;
    len = 0; hi = 0; seen_low = 0;
    forever begin
      if (rclk_o) hi++; else seen_low = 1;
      pos_i = (len == k) && p;
      neg_i = (len == k) && n;
      @(negedge clk);
      len++;
      if (seen_low && rclk_o) break;
    end
    pos_i = 1'b0;
    neg_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len, hi;
    repeat (3) @(negedge clk);
    chk(rx_pos_o == 0 && rx_neg_o == 0, "R1 data in reset", {rx_pos_o, rx_neg_o}, 0);
    chk(rclk_o == 1, "R1 rclk in reset", rclk_o, 1);
    rst_ni = 1'b1;
    run_period(-1, 0, 0, len, hi);
    chk(len == 13, "R3 first length", len, 13);
    chk(hi == 6, "R3 first high", hi, 6);

    for (int rail = 1; rail <= 3; rail++) begin
      for (int k = 0; k <= 12; k++) begin
        logic p, n;
        p = rail[0]; n = rail[1];
        run_period(k, p, n, len, hi);
        chk(len == k + 7, "R4 hit length", len, k + 7);
        chk(hi == imin(6, (k + 7) / 2), "R9 hit high", hi, imin(6, (k + 7) / 2));
        run_period(6, n, p, len, hi);
        chk(len == 13, "R6 centred length", len, 13);
        chk(hi == 6, "R3 centred high", hi, 6);
        chk({rx_pos_o, rx_neg_o} == {p, n}, "R5 rails", {rx_pos_o, rx_neg_o}, {p, n});
        run_period(-1, 0, 0, len, hi);
        chk(len == 13, "R3 empty length", len, 13);
        chk({rx_pos_o, rx_neg_o} == {n, p}, "R10 next bit", {rx_pos_o, rx_neg_o}, {n, p});
        run_period(-1, 0, 0, len, hi);
        chk({rx_pos_o, rx_neg_o} == 2'b00, "R2 zero bit", {rx_pos_o, rx_neg_o}, 0);
      end
    end

    los_i = 1'b1;
    for (int k = 0; k <= 12; k++) begin
      run_period(k, 1, 0, len, hi);
      chk(len == 13, "R7 los length", len, 13);
      chk(hi == 6, "R7 los high", hi, 6);
      run_period(-1, 0, 0, len, hi);
      chk({rx_pos_o, rx_neg_o} == 2'b10, "R8 los data", {rx_pos_o, rx_neg_o}, 2);
      run_period(-1, 0, 0, len, hi);
      chk({rx_pos_o, rx_neg_o} == 2'b00, "R2 los zero", {rx_pos_o, rx_neg_o}, 0);
    end
    los_i = 1'b0;

    run_period(3, 1, 1, len, hi);
    run_period(-1, 0, 0, len, hi);
    chk({rx_pos_o, rx_neg_o} == 2'b11, "R5 both rails", {rx_pos_o, rx_neg_o}, 3);
    rst_ni = 1'b0;
    #1;
    chk({rx_pos_o, rx_neg_o} == 2'b00, "R1 reset clears data", {rx_pos_o, rx_neg_o}, 0);
    chk(rclk_o == 1, "R1 reset rclk", rclk_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule